// File: doc/BRIEF.md
# Window Border Substitution Unit

This unit sits between a raster-scan window generator and the arithmetic stage of a 2-D filter. Each accepted cycle brings in one square window of N×N pixels around a centre position. The unit tracks where that centre lies in the image using its own row and column counters. Any tap of the window that lands outside the image is replaced before the window moves on, so the arithmetic stage never sees data from beyond the image edge.

Two border policies are available, chosen per frame. Zero fill forces outside taps to zero. Mirror reflection replaces each outside tap with the in-image pixel reflected across the nearest edge. Rows and columns are handled independently, so a corner tap is mirrored on both axes. The mirrored source is always one of the taps already present in the window, so no extra pixel storage is needed. The output window is registered and appears one cycle after its input.

The position tracker is a two-state machine. `ST_IDLE` waits for a start of frame. `ST_RUN` accepts windows in raster order. It has three named transitions:
- FRAME_START: `ST_IDLE`→`ST_RUN` on a valid window with start of frame.
- FRAME_END: `ST_RUN`→`ST_IDLE` when the window at the last row and last column is accepted.
- RESYNC: `ST_RUN`→`ST_RUN` when a start of frame arrives mid-frame; this resets the position to the origin.

Top module: `edge_window_border`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 until a window is accepted.
- R2: Tap t = i*N + j sits in bits [t*PW +: PW] on both `win_in` and `win_out`. Here i is the row offset index and j is the column offset index, with offset = index − (N−1)/2. A tap whose row and column both lie inside the image is passed through unchanged.
- R3: When the frame's mode is 0 (zero fill), every tap whose row or column lies outside 0..size−1 is output as 0.
- R4: When the frame's mode is 1 (mirror), each axis is mapped on its own. An index −k becomes k, and an index size−1+k becomes size−1−k. The outside tap takes the window pixel at the mapped row and column.
- R5: A window accepted at clock edge n appears on `win_out` with `out_valid` high after edge n+1's preceding edge, that is, exactly one cycle later. `out_valid` is high only in cycles following an accepted window.
- R6: The window marked with `in_sof` is at centre (0,0). Later windows advance in raster order, column first and wrapping to the next row after column IMG_W−1. Only accepted windows advance the position; idle cycles do not.
- R7: `mode_in` is sampled only with `in_sof`. Changing it during a frame has no effect on that frame's output.
- R8: A window with `in_valid` high but no `in_sof` is dropped, with no `out_valid`, in two cases: before the first start of frame, and after the last window of a frame (FRAME_END).
- R9: A start of frame arriving mid-frame restarts the position at (0,0) and takes the new mode.
- R10: When no window is accepted, `win_out` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A window is present on `win_in` |
| in_sof | input | 1 | This window is the first of a frame (centre at row 0, column 0) |
| mode_in | input | 1 | Border policy for the frame: 0 zero fill, 1 mirror |
| win_in | input | N*N*PW | Incoming window, taps packed as in R2 |
| out_valid | output | 1 | `win_out` carries a processed window |
| win_out | output | N*N*PW | Window after border substitution, same packing |

## Verification
The assertions take several things for granted about the inputs. `mode_in` is meaningful only alongside `in_sof`. Taps outside the image may carry arbitrary values. The image is larger than the window in both dimensions, so every mirrored index stays inside the current window. The stimulus follows these rules. It fills every outside tap with a marker value that no image pixel can take, so both a missed substitution and a wrong mirror source show up. It also toggles `mode_in` mid-frame, inserts idle gaps, issues a restart part-way through a frame, and offers windows while idle.

// File: rtl/edge_win_pkg.sv
package edge_win_pkg;

    // position tracker states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } trk_state_t;

    // border policy encoding on mode_in
    typedef enum logic [0:0] {
        BORDER_ZERO   = 1'b0,
        BORDER_MIRROR = 1'b1
    } border_mode_t;

endpackage

// File: rtl/edge_pos_tracker.sv
module edge_pos_tracker
    import edge_win_pkg::*;
#(
    parameter int IMG_W = 32,
    parameter int IMG_H = 32,
    parameter int CW    = $clog2(IMG_W),
    parameter int RW    = $clog2(IMG_H)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               mode_in,
    output logic               accept,
    output logic [RW-1:0]      row_now,
    output logic [CW-1:0]      col_now,
    output border_mode_t       mode_now,
    output logic               running
);

    trk_state_t   state_q, state_d;
    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;
    border_mode_t  mode_q;
    logic          last_win;
    logic          col_wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: FRAME_START, FRAME_END, RESYNC (stays in ST_RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_sof && !last_win) begin
                    state_d = ST_RUN;           // FRAME_START
                end
            end
            ST_RUN: begin
                if (last_win) begin
                    state_d = ST_IDLE;          // FRAME_END
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the tracker
    always_comb begin
        running  = (state_q == ST_RUN);
        accept   = in_valid && (in_sof || running);
        row_now  = in_sof ? '0 : row_q;
        col_now  = in_sof ? '0 : col_q;
        mode_now = in_sof ? border_mode_t'(mode_in) : mode_q;
        col_wrap = (col_now == CW'(IMG_W - 1));
        last_win = accept && col_wrap && (row_now == RW'(IMG_H - 1));
    end

    // raster position counters and frame mode latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            mode_q <= BORDER_ZERO;
        end else if (accept) begin
            mode_q <= mode_now;
            if (col_wrap) begin
                col_q <= '0;
                if (row_now == RW'(IMG_H - 1)) begin
                    row_q <= '0;
                end else begin
                    row_q <= row_now + 1'b1;
                end
            end else begin
                col_q <= col_now + 1'b1;
                row_q <= row_now;
            end
        end
    end

endmodule

// File: rtl/edge_axis_map.sv
module edge_axis_map #(
    parameter int N    = 5,
    parameter int SIZE = 32,
    parameter int AW   = $clog2(SIZE),
    parameter int IW   = $clog2(N)
) (
    input  logic [AW-1:0]         pos,
    output logic [N-1:0]          oob,
    output logic [N-1:0][IW-1:0]  sel
);

    localparam int HALF = (N - 1) / 2;

    // one bounds test and mirror index per window offset along this axis
    for (genvar k = 0; k < N; k++) begin : g_ofs
        localparam int OFS = k - HALF;
        int abs_idx;
        int src_idx;
        always_comb begin
            abs_idx = int'(pos) + OFS;
            if (abs_idx < 0) begin
                oob[k]  = 1'b1;
                src_idx = -abs_idx;
            end else if (abs_idx > SIZE - 1) begin
                oob[k]  = 1'b1;
                src_idx = 2 * (SIZE - 1) - abs_idx;
            end else begin
                oob[k]  = 1'b0;
                src_idx = abs_idx;
            end
            sel[k] = IW'(src_idx - int'(pos) + HALF);
        end
    end

endmodule

// File: rtl/edge_tap_mux.sv
module edge_tap_mux #(
    parameter int N  = 5,
    parameter int PW = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N*N*PW-1:0]     win_in,
    input  logic [N-1:0]          row_oob,
    input  logic [N-1:0]          col_oob,
    input  logic [N-1:0][IW-1:0]  row_sel,
    input  logic [N-1:0][IW-1:0]  col_sel,
    input  logic                  zero_fill,
    output logic [N*N*PW-1:0]     win_mux
);

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            localparam int T = i * N + j;
            logic [PW-1:0] src;
            always_comb begin
                src = win_in[(int'(row_sel[i]) * N + int'(col_sel[j])) * PW +: PW];
                if (zero_fill && (row_oob[i] || col_oob[j])) begin
                    win_mux[T*PW +: PW] = '0;
                end else begin
                    win_mux[T*PW +: PW] = src;
                end
            end
        end
    end

endmodule

// File: rtl/edge_window_border.sv
module edge_window_border
    import edge_win_pkg::*;
#(
    parameter int N     = 5,
    parameter int IMG_W = 32,
    parameter int IMG_H = 32,
    parameter int PW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 mode_in,
    input  logic [N*N*PW-1:0]    win_in,
    output logic                 out_valid,
    output logic [N*N*PW-1:0]    win_out
);

    localparam int CW = $clog2(IMG_W);
    localparam int RW = $clog2(IMG_H);
    localparam int IW = $clog2(N);

    logic                 accept;
    logic                 running;
    logic [RW-1:0]        row_now;
    logic [CW-1:0]        col_now;
    border_mode_t         mode_now;
    logic [N-1:0]         row_oob, col_oob;
    logic [N-1:0][IW-1:0] row_sel, col_sel;
    logic [N*N*PW-1:0]    win_mux;

    edge_pos_tracker #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .CW    (CW),
        .RW    (RW)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .mode_in  (mode_in),
        .accept   (accept),
        .row_now  (row_now),
        .col_now  (col_now),
        .mode_now (mode_now),
        .running  (running)
    );

    edge_axis_map #(
        .N    (N),
        .SIZE (IMG_H),
        .AW   (RW),
        .IW   (IW)
    ) u_rows (
        .pos (row_now),
        .oob (row_oob),
        .sel (row_sel)
    );

    edge_axis_map #(
        .N    (N),
        .SIZE (IMG_W),
        .AW   (CW),
        .IW   (IW)
    ) u_cols (
        .pos (col_now),
        .oob (col_oob),
        .sel (col_sel)
    );

    edge_tap_mux #(
        .N  (N),
        .PW (PW),
        .IW (IW)
    ) u_mux (
        .win_in    (win_in),
        .row_oob   (row_oob),
        .col_oob   (col_oob),
        .row_sel   (row_sel),
        .col_sel   (col_sel),
        .zero_fill (mode_now == BORDER_ZERO),
        .win_mux   (win_mux)
    );

    // output register, one cycle of latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            win_out   <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                win_out <= win_mux;
            end
        end
    end

endmodule

// File: rtl/edge_window_border_chk.sv
module edge_window_border_chk #(
    parameter int N  = 5,
    parameter int PW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sof,
    input logic              mode_in,
    input logic [N*N*PW-1:0] win_in,
    input logic              out_valid,
    input logic [N*N*PW-1:0] win_out,
    input logic              running
);

    localparam int NT  = N * N;
    localparam int CTR = (NT - 1) / 2;

    // R1: reset leaves no valid output behind
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R2: centre tap is always inside the image and passes unchanged
    assert_centre_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_sof || running)) |=>
            (win_out[CTR*PW +: PW] == $past(win_in[CTR*PW +: PW])));

    // R3: at the origin in zero mode the top-left tap is outside and zeroed
    assert_zero_corner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !mode_in) |=> (win_out[PW-1:0] == '0));

    // R4: at the origin in mirror mode the top-left tap takes the bottom-right tap
    assert_mirror_corner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && mode_in) |=>
            (win_out[PW-1:0] == $past(win_in[(NT-1)*PW +: PW])));

    // R5: a start of frame always yields a valid output next cycle
    assert_sof_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> out_valid);

    // R8: stray windows while idle are dropped
    assert_idle_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sof && !running) |=> !out_valid);

    // R10: without input the output window is held
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(win_out));

endmodule

bind edge_window_border edge_window_border_chk #(
    .N  (N),
    .PW (PW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .mode_in   (mode_in),
    .win_in    (win_in),
    .out_valid (out_valid),
    .win_out   (win_out),
    .running   (running)
);

// File: tb/sim_edge_window_border.sv
module sim_edge_window_border;

    localparam int N     = 5;
    localparam int IMG_W = 32;
    localparam int IMG_H = 32;
    localparam int PW    = 8;
    localparam int NT    = N * N;
    localparam int HALF  = (N - 1) / 2;
    localparam logic [PW-1:0] JUNK = 8'hFE;   // no image pixel takes this value

    localparam logic [3:0] TAG_R2 = 4'd2;
    localparam logic [3:0] TAG_R3 = 4'd3;
    localparam logic [3:0] TAG_R4 = 4'd4;
    localparam logic [3:0] TAG_R6 = 4'd6;
    localparam logic [3:0] TAG_R7 = 4'd7;
    localparam logic [3:0] TAG_R9 = 4'd9;

    typedef struct packed {
        logic [NT*PW-1:0] data;
        logic [31:0]      stamp;
        logic [3:0]       tag;
    } sb_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sof = 1'b0;
    logic              mode_in = 1'b0;
    logic [NT*PW-1:0]  win_in = '0;
    logic              out_valid;
    logic [NT*PW-1:0]  win_out;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [31:0] cyc = '0;
    sb_item_t    sbq[$];
    bit          done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    edge_window_border #(
        .N     (N),
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .PW    (PW)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .mode_in   (mode_in),
        .win_in    (win_in),
        .out_valid (out_valid),
        .win_out   (win_out)
    );

    function automatic string tag_name(logic [3:0] t);
        case (t)
            TAG_R2:  return "R2";
            TAG_R3:  return "R3";
            TAG_R4:  return "R4";
            TAG_R6:  return "R6";
            TAG_R7:  return "R7";
            TAG_R9:  return "R9";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [PW-1:0] img(int r, int c);
        return PW'(((r * 5 + c * 11) % 251) + 1);
    endfunction

    function automatic int mirror(int x, int size);
        if (x < 0) return -x;
        if (x > size - 1) return 2 * (size - 1) - x;
        return x;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // driver: present one window; push the expected result when it will be accepted
    task automatic send(int r, int c, bit sof, bit m_drive, bit m_eff, bit expect_out,
                        logic [3:0] tag_force);
        logic [NT*PW-1:0] raw;
        logic [NT*PW-1:0] exp_w;
        bit               any_oob;
        sb_item_t         it;
        any_oob = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                int rr = r + i - HALF;
                int cc = c + j - HALF;
                bit out_r = (rr < 0) || (rr > IMG_H - 1);
                bit out_c = (cc < 0) || (cc > IMG_W - 1);
                if (out_r || out_c) begin
                    any_oob = 1'b1;
                    raw[(i*N+j)*PW +: PW] = JUNK;
                    exp_w[(i*N+j)*PW +: PW] = m_eff ? img(mirror(rr, IMG_H), mirror(cc, IMG_W))
                                                    : '0;
                end else begin
                    raw[(i*N+j)*PW +: PW]   = img(rr, cc);
                    exp_w[(i*N+j)*PW +: PW] = img(rr, cc);
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = sof;
        mode_in  = m_drive;
        win_in   = raw;
        if (expect_out) begin
            it.data  = exp_w;
            it.stamp = cyc;
            if (tag_force != 4'd0)       it.tag = tag_force;
            else if (m_drive != m_eff)   it.tag = TAG_R7;
            else if (!any_oob)           it.tag = TAG_R2;
            else if (m_eff)              it.tag = TAG_R4;
            else                         it.tag = TAG_R3;
            sbq.push_back(it);
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sof   = 1'b0;
        end
    endtask

    // full or partial frame; idle gaps exercise position hold (R6)
    task automatic run_frame(bit m_start, int toggle_at, int stop_at, logic [3:0] tag_first_rows);
        for (int idx = 0; idx < stop_at; idx++) begin
            int  r = idx / IMG_W;
            int  c = idx % IMG_W;
            bit  md = (toggle_at >= 0 && idx >= toggle_at) ? ~m_start : m_start;
            logic [3:0] tf = (idx < IMG_W) ? tag_first_rows : 4'd0;
            if (idx % 7 == 3) idle(1);
            send(r, c, idx == 0, md, m_start, 1'b1, tf);
        end
    endtask

    // monitor: compare data and cycle of every produced window
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R8", 64'd1, 64'd0);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                n_checks++;
                if (win_out !== it.data) begin
                    n_fails++;
                    $display("FAIL %s: window got %h expected %h", tag_name(it.tag), win_out, it.data);
                end
                check(cyc == it.stamp + 1, "R5", 64'(cyc), 64'(it.stamp + 1));
            end
        end
    end

    initial begin
        logic [NT*PW-1:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);

        // R8: stray windows before any start of frame
        send(4, 4, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        send(4, 5, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0);
        idle(1);
        check(out_valid == 1'b0, "R8", 64'(out_valid), 64'd0);

        // zero-fill frame with gaps: R2, R3, R6
        run_frame(1'b0, -1, IMG_W * IMG_H, TAG_R6);
        // R8: stray window right after FRAME_END
        send(0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        idle(1);
        check(out_valid == 1'b0, "R8", 64'(out_valid), 64'd0);

        // R10: output held while idle
        idle(1);
        held = win_out;
        idle(4);
        check(win_out == held, "R10", win_out[63:0], held[63:0]);

        // mirror frame, mode input flipped part-way: R4, R7
        run_frame(1'b1, 300, IMG_W * IMG_H, 4'd0);
        idle(3);

        // partial zero frame, then restart in mirror mode: R9
        run_frame(1'b0, -1, 45, 4'd0);
        run_frame(1'b1, -1, IMG_W * IMG_H, TAG_R9);
        idle(4);
        check(sbq.size() == 0, "R5", 64'(sbq.size()), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule